// File: doc/BRIEF.md
# Ethernet destination address recognizer

This block takes the 48-bit destination address of a received frame and reports whether the frame is kept. The individual/group bit of the address picks one of two paths. The individual path accepts on an exact match against the programmed station address, or on a hit in the individual hash table. The group path first checks for the all-ones broadcast address. Any other group address goes to the group hash table.

When no on-chip check matches, the block falls back to one of two actions. It can accept everything (promiscuous mode), or it can ask an external content-addressable match engine for a verdict. The hash computation and the tables sit outside the block. They are reached through a request/acknowledge lookup port. The external match engine is reached through a second handshake of the same kind.

Each frame gives exactly one decision: a single-cycle valid pulse with an accept flag.

Top module: `eth_da_filter`

## Requirements
- R1: While `rst_ni` is low, `hash_req_o`, `cam_req_o`, `dec_valid_o` and `dec_accept_o` are all 0.
- R2: Bit 40 of `dest_addr_i` (bit 0 of the first octet, `dest_addr_i[47:40]`) selects the path: 0 means individual, 1 means group. An individual address equal to `station_addr_i` is accepted, whatever the hash result.
- R3: An individual address that does not match the station address is accepted only if its hash lookup returns a hit. Programming an all-ones station address and answering every lookup with a miss rejects all individual frames (promiscuous mode and CAM off).
- R4: Every non-broadcast frame issues one hash lookup. `hash_req_o` stays high until the cycle in which `hash_ack_i` is sampled. `hash_key_o` carries the frame's address throughout.
- R5: The all-ones broadcast address is accepted when `bcast_en_i` is 1, and no hash lookup is issued for it.
- R6: A broadcast frame with `bcast_en_i` at 0 issues no hash lookup. It goes straight to the fallback: the promiscuous setting, or the CAM when that is enabled.
- R7: A group address that is not broadcast is looked up with `hash_grp_o` at 1. It is accepted only on a hit.
- R8: With the CAM disabled and no on-chip match, the frame is accepted exactly when `promisc_en_i` is 1.
- R9: With `cam_en_i` at 1 and an on-chip match, the frame is accepted and `cam_req_o` stays low.
- R10: With `cam_en_i` at 1 and no on-chip match, `cam_req_o` rises and stays high until `cam_ack_i` is sampled. `cam_key_o` carries the address. The decision equals `cam_hit_i`, and `promisc_en_i` has no effect.
- R11: `dec_valid_o` is a one-cycle pulse. It rises in the cycle after the edge that samples the last result needed: the frame itself for a broadcast decided on chip, `hash_ack_i`, or `cam_ack_i`. `dec_accept_o` is 0 whenever `dec_valid_o` is 0.
- R12: A `frame_valid_i` pulse that arrives while a lookup is outstanding is ignored. It causes no second decision and does not change the keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | One-cycle strobe: dest_addr_i is valid |
| dest_addr_i | input | 48 | Destination address, first octet in [47:40] |
| station_addr_i | input | 48 | Programmed station address |
| bcast_en_i | input | 1 | Accept broadcast frames |
| promisc_en_i | input | 1 | Accept all frames when the CAM is off |
| cam_en_i | input | 1 | Use the external match engine as fallback |
| hash_req_o | output | 1 | Hash lookup request |
| hash_grp_o | output | 1 | 1: group table, 0: individual table |
| hash_key_o | output | 48 | Address to hash |
| hash_ack_i | input | 1 | Hash lookup done |
| hash_hit_i | input | 1 | Hash bin set, valid with hash_ack_i |
| cam_req_o | output | 1 | External match request |
| cam_key_o | output | 48 | Address to match |
| cam_ack_i | input | 1 | External match done |
| cam_hit_i | input | 1 | Match found, valid with cam_ack_i |
| dec_valid_o | output | 1 | Decision strobe |
| dec_accept_o | output | 1 | Frame accepted, valid with dec_valid_o |

## Verification
The hardest state to reach from the ports is a second frame strobe landing while a lookup is still outstanding. The other hard case is a disabled broadcast that must skip the hash and still reach the external match engine.

The bench drives the hash and CAM responders itself, with a latency chosen per frame. This holds either handshake open for several cycles. A stray strobe is injected into that window. Disabled broadcasts are sent under each fallback setting.

The remaining paths are covered by random addresses, random configuration and random latencies, all checked against a behavioural model on every cycle.

// File: rtl/eth_daf_pkg.sv
package eth_daf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HASH = 2'd1,
    ST_CAM  = 2'd2
  } daf_state_e;

  typedef struct packed {
    logic indiv;
    logic bcast;
    logic exact;
  } daf_class_t;
endpackage

// File: rtl/eth_daf_classify.sv
module eth_daf_classify
  import eth_daf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IG_BIT = 40
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] station_i,
  output daf_class_t        class_o
);
  always_comb begin
    class_o.indiv = ~addr_i[IG_BIT];
    class_o.bcast = &addr_i;
    class_o.exact = (addr_i == station_i);
  end
endmodule

// File: rtl/eth_daf_resolve.sv
module eth_daf_resolve
  import eth_daf_pkg::*;
(
  input  daf_class_t class_i,
  input  logic       hash_hit_i,
  input  logic       bcast_en_i,
  input  logic       promisc_en_i,
  input  logic       cam_en_i,
  output logic       need_cam_o,
  output logic       accept_o
);
  logic onchip;

  always_comb begin
    if (class_i.indiv)      onchip = class_i.exact | hash_hit_i;
    else if (class_i.bcast) onchip = bcast_en_i;  // disabled bcast skips group hash
    else                    onchip = hash_hit_i;
    need_cam_o = ~onchip & cam_en_i;
    accept_o   = onchip | promisc_en_i;
  end
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import eth_daf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OCTET_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_valid_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              bcast_en_i,
  input  logic              promisc_en_i,
  input  logic              cam_en_i,
  output logic              hash_req_o,
  output logic              hash_grp_o,
  output logic [ADDR_W-1:0] hash_key_o,
  input  logic              hash_ack_i,
  input  logic              hash_hit_i,
  output logic              cam_req_o,
  output logic [ADDR_W-1:0] cam_key_o,
  input  logic              cam_ack_i,
  input  logic              cam_hit_i,
  output logic              dec_valid_o,
  output logic              dec_accept_o
);
  localparam int IG_BIT = ADDR_W - OCTET_W;

  daf_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  daf_class_t        cls_q, cls_live, cls_use;
  logic              need_cam, acc;

  eth_daf_classify #(.ADDR_W(ADDR_W), .IG_BIT(IG_BIT)) u_classify (
    .addr_i    (dest_addr_i),
    .station_i (station_addr_i),
    .class_o   (cls_live)
  );

  assign cls_use = (state_q == ST_IDLE) ? cls_live : cls_q;

  eth_daf_resolve u_resolve (
    .class_i      (cls_use),
    .hash_hit_i   (hash_hit_i),
    .bcast_en_i   (bcast_en_i),
    .promisc_en_i (promisc_en_i),
    .cam_en_i     (cam_en_i),
    .need_cam_o   (need_cam),
    .accept_o     (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      cls_q        <= '0;
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
    end else begin
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (frame_valid_i) begin
          addr_q <= dest_addr_i;
          cls_q  <= cls_live;
          if (!cls_live.bcast)  state_q <= ST_HASH;
          else if (need_cam)    state_q <= ST_CAM;
          else begin
            dec_valid_o  <= 1'b1;
            dec_accept_o <= acc;
          end
        end
        ST_HASH: if (hash_ack_i) begin
          if (need_cam) state_q <= ST_CAM;
          else begin
            state_q      <= ST_IDLE;
            dec_valid_o  <= 1'b1;
            dec_accept_o <= acc;
          end
        end
        ST_CAM: if (cam_ack_i) begin
          state_q      <= ST_IDLE;
          dec_valid_o  <= 1'b1;
          dec_accept_o <= cam_hit_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hash_req_o = (state_q == ST_HASH);
  assign hash_grp_o = ~cls_q.indiv;
  assign hash_key_o = addr_q;
  assign cam_req_o  = (state_q == ST_CAM);
  assign cam_key_o  = addr_q;

  // R4
  hash_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && !hash_ack_i |=> hash_req_o && $stable(hash_key_o));
  // R10
  cam_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cam_req_o && !cam_ack_i |=> cam_req_o && $stable(cam_key_o));
  // R10
  cam_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cam_req_o) |-> cam_en_i);
  // R11
  accept_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_accept_o |-> dec_valid_o);
  // R12
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hash_req_o && cam_req_o) && !(cam_req_o && dec_valid_o));
endmodule

// File: tb/eth_da_filter_tb.sv
`timescale 1ns/1ps
module eth_da_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_valid = 1'b0;
  logic [47:0] da = '0, station = 48'h0200_1122_3344;
  logic bcast_en = 1'b0, promisc = 1'b0, cam_en = 1'b0;
  logic hash_ack = 1'b0, hash_hit = 1'b0, cam_ack = 1'b0, cam_hit = 1'b0;
  logic hash_req, hash_grp, cam_req, dec_valid, dec_accept;
  logic [47:0] hash_key, cam_key;

  int vectors = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  eth_da_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(frame_valid), .dest_addr_i(da),
    .station_addr_i(station), .bcast_en_i(bcast_en), .promisc_en_i(promisc),
    .cam_en_i(cam_en), .hash_req_o(hash_req), .hash_grp_o(hash_grp),
    .hash_key_o(hash_key), .hash_ack_i(hash_ack), .hash_hit_i(hash_hit),
    .cam_req_o(cam_req), .cam_key_o(cam_key), .cam_ack_i(cam_ack),
    .cam_hit_i(cam_hit), .dec_valid_o(dec_valid), .dec_accept_o(dec_accept));

  // behavioural reference: phase 0 idle, 1 waiting on hash, 2 waiting on CAM
  int phase = 0;
  logic [47:0] m_da = '0;
  bit m_indiv = 0, m_exact = 0, e_valid = 0, e_acc = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; e_valid = 0; e_acc = 0;
    end else begin
      bit onchip, decide;
      decide = 0; onchip = 0;
      e_valid = 0; e_acc = 0;
      if (phase == 0 && frame_valid) begin
        m_da = da; m_indiv = (da[40] == 1'b0); m_exact = (da == station);
        if (da == {48{1'b1}}) begin onchip = bcast_en; decide = 1; end
        else phase = 1;
      end else if (phase == 1 && hash_ack) begin
        onchip = m_indiv ? (m_exact || hash_hit) : hash_hit;
        decide = 1;
      end else if (phase == 2 && cam_ack) begin
        e_valid = 1; e_acc = cam_hit; phase = 0;
      end
      if (decide) begin
        if (onchip) begin e_valid = 1; e_acc = 1; phase = 0; end
        else if (cam_en) phase = 2;
        else begin e_valid = 1; e_acc = promisc; phase = 0; end
      end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", r, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(dec_valid == e_valid, "R11", 48'(dec_valid), 48'(e_valid));
    chk(dec_accept == (e_valid & e_acc), tag, 48'(dec_accept), 48'(e_valid & e_acc));
    chk(hash_req == (phase == 1), "R4", 48'(hash_req), 48'(phase == 1));
    chk(cam_req == (phase == 2), "R10", 48'(cam_req), 48'(phase == 2));
    if (phase == 1) begin
      chk(hash_key == m_da, "R4", hash_key, m_da);
      chk(hash_grp == !m_indiv, "R7", 48'(hash_grp), 48'(!m_indiv));
    end
    if (phase == 2) chk(cam_key == m_da, "R10", cam_key, m_da);
  end

  task automatic send(input logic [47:0] a, input int hl, input bit hh,
                      input int cl, input bit ch, input bit poke, input string t);
    int hc = 0, cc = 0;
    tag = t;
    @(negedge clk); da = a; frame_valid = 1;
    @(negedge clk); frame_valid = 0;
    for (int i = 0; i < 40; i++) begin
      hash_ack = 0; cam_ack = 0;
      frame_valid = poke && i == 0;
      if (poke && i == 0) da = ~a ^ 48'h0100_0000_0000;
      if (hash_req) begin
        if (hc == hl) begin hash_ack = 1; hash_hit = hh; end
        hc++;
      end
      if (cam_req) begin
        if (cc == cl) begin cam_ack = 1; cam_hit = ch; end
        cc++;
      end
      @(negedge clk);
      frame_valid = 0;
    end
    hash_ack = 0; cam_ack = 0;
  endtask

  task automatic cfg(input bit b, input bit p, input bit c);
    bcast_en = b; promisc = p; cam_en = c;
  endtask

  localparam logic [47:0] BC  = {48{1'b1}};
  localparam logic [47:0] GRP = 48'h0100_5e00_0001;
  localparam logic [47:0] IND = 48'h0a00_2700_0007;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!hash_req && !cam_req && !dec_valid && !dec_accept, "R1",
        {44'd0, hash_req, cam_req, dec_valid, dec_accept}, 48'd0);
    @(negedge clk); rst_n = 1;
    cfg(0, 0, 0);
    send(station, 0, 0, 0, 0, 0, "R2");
    send(IND, 1, 1, 0, 0, 0, "R3");
    send(IND, 0, 0, 0, 0, 0, "R3");
    station = BC;
    send(IND, 2, 0, 0, 0, 0, "R3");
    send(48'h0000_0000_0001, 0, 0, 0, 0, 0, "R3");
    station = 48'h0200_1122_3344;
    send(IND, 5, 1, 0, 0, 0, "R4");
    cfg(1, 0, 0); send(BC, 0, 0, 0, 0, 0, "R5");
    cfg(0, 0, 0); send(BC, 0, 1, 0, 0, 0, "R6");
    cfg(0, 1, 0); send(BC, 0, 0, 0, 0, 0, "R6");
    cfg(0, 0, 1); send(BC, 0, 0, 2, 1, 0, "R6");
    cfg(1, 0, 0); send(GRP, 1, 1, 0, 0, 0, "R7");
    send(GRP, 0, 0, 0, 0, 0, "R7");
    cfg(0, 1, 0); send(GRP, 0, 0, 0, 0, 0, "R8");
    send(IND, 3, 0, 0, 0, 0, "R8");
    cfg(0, 0, 1); send(station, 0, 0, 0, 1, 0, "R9");
    send(GRP, 1, 1, 0, 0, 0, "R9");
    send(GRP, 1, 0, 3, 1, 0, "R10");
    send(IND, 0, 0, 0, 0, 0, "R10");
    cfg(0, 1, 1); send(IND, 0, 0, 1, 0, 0, "R10");
    cfg(0, 0, 0); send(IND, 4, 1, 0, 0, 1, "R12");
    cfg(0, 0, 1); send(GRP, 0, 0, 4, 1, 1, "R12");
    for (int k = 0; k < 300; k++) begin
      logic [47:0] a;
      int sel;
      sel = $urandom_range(0, 4);
      a = {$urandom, $urandom} ;
      if (sel == 0) a = station;
      if (sel == 1) a = BC;
      cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      send(a, $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
           $urandom_range(0, 1), $urandom_range(0, 1) && sel > 1, "R11");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule